// File: doc/BRIEF.md
# Parallel Modulation Port Controller

This block takes 32-bit words from a wide parallel modulation port and steers them, according to a 4-bit function code, into holding registers for a synthesizer core's frequency tuning word, phase offset word and amplitude word. The port is sampled once per slot. A slot is one clock in every sixteen, timed by an internal divider that also drives the `slot_tick` output.

A mode input selects how captured values reach the core. In streaming mode, each write goes straight on toward the core-side outputs. In staged mode, writes stay in the holding registers. An update pulse then releases every staged parameter at once, so several slots with different function codes can be combined into one core change. Each parameter path has its own native delay. A matched-latency control pads all three paths to a common delay. An amplitude-control enable either passes the amplitude word to the core or forces full scale.

A small state machine tracks the staging mode. Its states are `ST_STREAM` (writes pass straight through), `ST_EMPTY` (staged mode, nothing pending) and `ST_ARMED` (staged mode, at least one parameter pending). Any state goes to `ST_STREAM` when `stream_en` is high. `ST_STREAM` goes to `ST_EMPTY` when `stream_en` falls. `ST_EMPTY` goes to `ST_ARMED` on a decoded write. `ST_ARMED` goes back to `ST_EMPTY` on an update pulse unless a write lands on the same edge. The mode register follows `stream_en` one clock later.

Top module: `param_mod_port`

## Requirements
- R1: `slot_tick` is high for exactly one clock in every 16. After reset is released, it first rises in the 16th clock. The rising edge that closes a `slot_tick` cycle is the only edge that samples `port_func` and `port_data`.
- R2: Function code 4'b0010 loads all 32 bits of `port_data` as the new frequency word.
- R3: Function code 4'b0100 loads the phase word from bits [31:16] and the amplitude word from bits [11:0] in the same slot. Bits [15:12] have no effect.
- R4: Any other function code changes none of the three parameters.
- R5: In streaming mode, a write reaches the core-side outputs without an update pulse. Counting the sampling edge as edge 1, frequency changes at edge 2, phase at edge 3 and amplitude at edge 4.
- R6: In staged mode, core-side outputs do not change until `update_pulse` is sampled high. Every parameter staged since the last release then follows with the same per-path delay, counted from the update edge. Two slots with different codes can be released by one pulse.
- R7: An update pulse with nothing pending changes no output. This includes a second pulse after a release.
- R8: With `match_lat_en` high, frequency, phase and amplitude all change at edge 4 after the sampling edge or update edge. Before that edge they keep their old values.
- R9: `core_amp` shows the amplitude word when `amp_ctl_en` is 1 and shows 12'hFFF when it is 0.
- R10: A synchronous active-high reset clears the divider, the holding registers and the core-side registers to zero.
- R11: Entering streaming mode discards staged writes. A later update pulse in staged mode then changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| port_data | input | 32 | Parallel modulation data word |
| port_func | input | 4 | Function code selecting the destination |
| stream_en | input | 1 | 1 = streaming, 0 = staged until update |
| match_lat_en | input | 1 | 1 = pad all paths to the common delay |
| amp_ctl_en | input | 1 | 1 = amplitude word drives the core, 0 = full scale |
| update_pulse | input | 1 | Releases staged parameters in staged mode |
| slot_tick | output | 1 | High in the cycle whose closing edge samples the port |
| core_freq | output | 32 | Core-side frequency word |
| core_phase | output | 16 | Core-side phase word |
| core_amp | output | 12 | Core-side amplitude word |

## Verification
The bench targets the cycle each path updates on. A design with swapped or unpadded delays shows the new value one or two clocks early or late, and this is checked both before and at the expected edge in matched mode. It stages a frequency slot and an amplitude/phase slot, checks the outputs stay frozen, then fires one update. A design that leaks staged values, or releases only the last slot, fails this. It also fires repeated and stale updates after a release and after a trip through streaming mode; a design that keeps pending flags would change outputs there. Undecoded codes and the ignored bits [15:12] are driven with values that would be visible if they were decoded.

// File: rtl/param_mod_pkg.sv
package param_mod_pkg;

    localparam logic [3:0] FN_FREQ  = 4'b0010;
    localparam logic [3:0] FN_AMPPH = 4'b0100;

    typedef enum logic [1:0] {
        ST_STREAM = 2'd0,
        ST_EMPTY  = 2'd1,
        ST_ARMED  = 2'd2
    } stage_state_e;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/param_slot_timer.sv
module param_slot_timer #(
    parameter int DIV = 16
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)               cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else                   cnt_q <= cnt_q + 1'b1;
    end

    assign tick = (cnt_q == LAST);

    AST_TICK_SPACED: assert property (@(posedge clk) disable iff (rst) tick |=> !tick);  // R1

endmodule

// File: rtl/param_stage_ctrl.sv
module param_stage_ctrl
    import param_mod_pkg::*;
#(
    parameter int DW = 32,
    parameter int FW = 32,
    parameter int PW = 16,
    parameter int AW = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic [3:0]    func,
    input  logic [DW-1:0] data,
    input  logic          stream_en,
    input  logic          update,
    output logic          rel_f_v,
    output logic          rel_p_v,
    output logic          rel_a_v,
    output logic [FW-1:0] rel_f,
    output logic [PW-1:0] rel_p,
    output logic [AW-1:0] rel_a
);
    localparam int NPAR = 3;

    stage_state_e state_q, state_d;
    logic [NPAR-1:0] pend_q, pend_d, wr, rel;
    logic [FW-1:0]   hold_f;
    logic [PW-1:0]   hold_p;
    logic [AW-1:0]   hold_a;
    logic [FW-1:0]   in_f;
    logic [PW-1:0]   in_p;
    logic [AW-1:0]   in_a;

    assign in_f = data[FW-1:0];
    assign in_p = data[DW-1 -: PW];
    assign in_a = data[AW-1:0];

    always_comb begin
        wr[0] = tick && (func == FN_FREQ);
        wr[1] = tick && (func == FN_AMPPH);
        wr[2] = tick && (func == FN_AMPPH);
    end

    // holding registers
    always_ff @(posedge clk) begin
        if (rst) begin
            hold_f <= '0;
            hold_p <= '0;
            hold_a <= '0;
        end else begin
            if (wr[0]) hold_f <= in_f;
            if (wr[1]) hold_p <= in_p;
            if (wr[2]) hold_a <= in_a;
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_EMPTY;
            pend_q  <= '0;
        end else begin
            state_q <= state_d;
            pend_q  <= pend_d;
        end
    end

    // next state and release outputs
    always_comb begin
        rel     = '0;
        rel_f   = hold_f;
        rel_p   = hold_p;
        rel_a   = hold_a;
        pend_d  = pend_q;
        unique case (state_q)
            ST_STREAM: begin
                rel    = wr;
                rel_f  = in_f;
                rel_p  = in_p;
                rel_a  = in_a;
                pend_d = '0;
            end
            ST_EMPTY: begin
                pend_d = wr;
            end
            ST_ARMED: begin
                if (update) rel = pend_q;
                pend_d = (pend_q & ~rel) | wr;
            end
            default: begin
                pend_d = '0;
            end
        endcase
        if (stream_en)      state_d = ST_STREAM;
        else if (|pend_d)   state_d = ST_ARMED;
        else                state_d = ST_EMPTY;
        if (stream_en && state_q != ST_STREAM) pend_d = '0;
    end

    assign rel_f_v = rel[0];
    assign rel_p_v = rel[1];
    assign rel_a_v = rel[2];

    AST_UNDECODED_KEEP: assert property (@(posedge clk) disable iff (rst)
        (tick && func != FN_FREQ && func != FN_AMPPH) |=> ($stable(hold_f) && $stable(hold_p) && $stable(hold_a)));  // R4
    AST_STAGED_QUIET: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_STREAM && !update) |-> !(rel_f_v || rel_p_v || rel_a_v));  // R6
    AST_IDLE_UPDATE: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_STREAM && update && pend_q == '0) |-> !(rel_f_v || rel_p_v || rel_a_v));  // R7
    AST_STREAM_CLEAN: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_STREAM) |=> (pend_q == '0));  // R11

endmodule

// File: rtl/param_delay_line.sv
module param_delay_line #(
    parameter int DW      = 32,
    parameter int NATIVE  = 2,
    parameter int MATCHED = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          matched,
    input  logic          in_v,
    input  logic [DW-1:0] in_d,
    output logic [DW-1:0] out_d
);
    localparam int NST = MATCHED - 1;

    logic          tap_v;
    logic [DW-1:0] tap_d;

    for (genvar k = 0; k < NST; k++) begin : g_st
        logic          v;
        logic [DW-1:0] d;
        if (k == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) begin
                    v <= 1'b0;
                    d <= '0;
                end else begin
                    v <= in_v;
                    d <= in_d;
                end
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) begin
                    v <= 1'b0;
                    d <= '0;
                end else begin
                    v <= g_st[k-1].v;
                    d <= g_st[k-1].d;
                end
            end
        end
    end

    always_comb begin
        if (matched) begin
            tap_v = g_st[MATCHED-2].v;
            tap_d = g_st[MATCHED-2].d;
        end else begin
            tap_v = g_st[NATIVE-2].v;
            tap_d = g_st[NATIVE-2].d;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)        out_d <= '0;
        else if (tap_v) out_d <= tap_d;
    end

endmodule

// File: rtl/param_mod_port.sv
module param_mod_port
    import param_mod_pkg::*;
#(
    parameter int DIV       = 16,
    parameter int DW        = 32,
    parameter int FW        = 32,
    parameter int PW        = 16,
    parameter int AW        = 12,
    parameter int LAT_FREQ  = 2,
    parameter int LAT_PHASE = 3,
    parameter int LAT_AMP   = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [31:0]   port_data,
    input  logic [3:0]    port_func,
    input  logic          stream_en,
    input  logic          match_lat_en,
    input  logic          amp_ctl_en,
    input  logic          update_pulse,
    output logic          slot_tick,
    output logic [31:0]   core_freq,
    output logic [15:0]   core_phase,
    output logic [11:0]   core_amp
);
    localparam int LAT_MAX = max3(LAT_FREQ, LAT_PHASE, LAT_AMP);

    logic          rf_v, rp_v, ra_v;
    logic [FW-1:0] rf;
    logic [PW-1:0] rp;
    logic [AW-1:0] ra;
    logic [AW-1:0] amp_q;

    param_slot_timer #(.DIV(DIV)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .tick (slot_tick)
    );

    param_stage_ctrl #(.DW(DW), .FW(FW), .PW(PW), .AW(AW)) u_stage (
        .clk       (clk),
        .rst       (rst),
        .tick      (slot_tick),
        .func      (port_func),
        .data      (port_data),
        .stream_en (stream_en),
        .update    (update_pulse),
        .rel_f_v   (rf_v),
        .rel_p_v   (rp_v),
        .rel_a_v   (ra_v),
        .rel_f     (rf),
        .rel_p     (rp),
        .rel_a     (ra)
    );

    param_delay_line #(.DW(FW), .NATIVE(LAT_FREQ), .MATCHED(LAT_MAX)) u_dl_freq (
        .clk (clk), .rst (rst), .matched (match_lat_en),
        .in_v (rf_v), .in_d (rf), .out_d (core_freq)
    );

    param_delay_line #(.DW(PW), .NATIVE(LAT_PHASE), .MATCHED(LAT_MAX)) u_dl_phase (
        .clk (clk), .rst (rst), .matched (match_lat_en),
        .in_v (rp_v), .in_d (rp), .out_d (core_phase)
    );

    param_delay_line #(.DW(AW), .NATIVE(LAT_AMP), .MATCHED(LAT_MAX)) u_dl_amp (
        .clk (clk), .rst (rst), .matched (match_lat_en),
        .in_v (ra_v), .in_d (ra), .out_d (amp_q)
    );

    assign core_amp = amp_ctl_en ? amp_q : {AW{1'b1}};

    AST_QUIET_NO_TICK: assert property (@(posedge clk) disable iff (rst)
        (stream_en && $past(stream_en) && !slot_tick && !$past(slot_tick) && !$past(slot_tick, 2) && !$past(slot_tick, 3) && !$past(slot_tick, 4) && !$past(slot_tick, 5) && $past(!rst, 5))
        |=> $stable(core_freq) && $stable(core_phase));  // R5

endmodule

// File: tb/param_mod_port_bench.sv
module param_mod_port_bench;

    typedef struct {
        int          due;
        logic [31:0] val;
        string       req;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] port_data = '0;
    logic [3:0]  port_func = 4'h0;
    logic        stream_en = 1'b1;
    logic        match_lat_en = 1'b0;
    logic        amp_ctl_en = 1'b1;
    logic        update_pulse = 1'b0;
    logic        slot_tick;
    logic [31:0] core_freq;
    logic [15:0] core_phase;
    logic [11:0] core_amp;

    int compared = 0;
    int mismatched = 0;
    int cyc = 0;

    exp_t qf[$];
    exp_t qp[$];
    exp_t qa[$];

    // model of core values (latest scheduled), holding registers, pending flags
    logic [31:0] mf = '0;
    logic [15:0] mp = '0;
    logic [11:0] ma = '0;
    logic [31:0] hf = '0;
    logic [15:0] hp = '0;
    logic [11:0] ha = '0;
    logic pf = 0, pp = 0, pa = 0;

    always #2.5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    param_mod_port u_param_mod_port (
        .clk          (clk),
        .rst          (rst),
        .port_data    (port_data),
        .port_func    (port_func),
        .stream_en    (stream_en),
        .match_lat_en (match_lat_en),
        .amp_ctl_en   (amp_ctl_en),
        .update_pulse (update_pulse),
        .slot_tick    (slot_tick),
        .core_freq    (core_freq),
        .core_phase   (core_phase),
        .core_amp     (core_amp)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s cyc=%0d actual=%h expected=%h", req, cyc, act, exp);
        end
    endtask

    // monitor: pops expected items when due
    always @(negedge clk) begin
        if (!rst) begin
            while (qf.size() > 0 && qf[0].due <= cyc) begin
                chk({qf[0].req, " freq"}, core_freq, qf[0].val);
                void'(qf.pop_front());
            end
            while (qp.size() > 0 && qp[0].due <= cyc) begin
                chk({qp[0].req, " phase"}, {16'h0, core_phase}, qp[0].val);
                void'(qp.pop_front());
            end
            while (qa.size() > 0 && qa[0].due <= cyc) begin
                chk({qa[0].req, " amp"}, {20'h0, core_amp}, qa[0].val);
                void'(qa.pop_front());
            end
        end
    end

    function automatic int lat_f();
        return match_lat_en ? 4 : 2;
    endfunction
    function automatic int lat_p();
        return match_lat_en ? 4 : 3;
    endfunction

    task automatic push_f(input int due, input logic [31:0] v, input string req);
        exp_t e; e.due = due; e.val = v; e.req = req; qf.push_back(e);
    endtask
    task automatic push_p(input int due, input logic [15:0] v, input string req);
        exp_t e; e.due = due; e.val = {16'h0, v}; e.req = req; qp.push_back(e);
    endtask
    task automatic push_a(input int due, input logic [11:0] v, input string req);
        exp_t e; e.due = due; e.val = {20'h0, v}; e.req = req; qa.push_back(e);
    endtask

    // driver: one port write in the next slot
    task automatic port_write(input logic [3:0] fn, input logic [31:0] d, input string req);
        int n;
        @(negedge clk);
        while (!slot_tick) @(negedge clk);
        port_func = fn;
        port_data = d;
        @(posedge clk);
        #1 n = cyc;
        if (fn == 4'b0010) begin
            hf = d;
            if (stream_en) begin
                if (match_lat_en) push_f(n + 1, mf, {req, " early"});
                mf = d;
                push_f(n + lat_f() - 1, mf, req);
            end else pf = 1;
        end else if (fn == 4'b0100) begin
            hp = d[31:16];
            ha = d[11:0];
            if (stream_en) begin
                if (match_lat_en) begin
                    push_p(n + 1, mp, {req, " early"});
                    push_a(n + 2, ma, {req, " early"});
                end
                mp = hp;
                ma = ha;
                push_p(n + lat_p() - 1, mp, req);
                push_a(n + 3, ma, req);
            end else begin
                pp = 1;
                pa = 1;
            end
        end
        @(negedge clk);
        port_func = 4'h0;
        port_data = 32'hA5A5_5A5A;
    endtask

    task automatic pulse_update(input string req);
        int n;
        @(negedge clk);
        update_pulse = 1'b1;
        @(posedge clk);
        #1 n = cyc;
        if (!stream_en) begin
            if (pf) begin mf = hf; push_f(n + lat_f() - 1, mf, req); end
            if (pp) begin mp = hp; push_p(n + lat_p() - 1, mp, req); end
            if (pa) begin ma = ha; push_a(n + 3, ma, req); end
            pf = 0; pp = 0; pa = 0;
        end
        @(negedge clk);
        update_pulse = 1'b0;
    endtask

    // expect the current model values to still hold a few clocks from now
    task automatic expect_hold(input string req);
        int n;
        n = cyc + 6;
        push_f(n, mf, req);
        push_p(n, mp, req);
        push_a(n, ma, req);
    endtask

    task automatic set_mode(input logic s, input logic m);
        @(negedge clk);
        if (s && !stream_en) begin pf = 0; pp = 0; pa = 0; end
        stream_en = s;
        match_lat_en = m;
        repeat (3) @(negedge clk);
    endtask

    task automatic drain();
        while (qf.size() > 0 || qp.size() > 0 || qa.size() > 0) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog expired at cyc=%0d actual=hung expected=done", cyc);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin : main
        int r;
        int first;
        repeat (4) @(negedge clk);
        // R10: reset state
        chk("R10 reset", core_freq, 32'h0);
        chk("R10 reset", {16'h0, core_phase}, 32'h0);
        chk("R10 reset", {20'h0, core_amp}, 32'h0);
        chk("R10 reset tick", {31'h0, slot_tick}, 32'h0);
        rst = 1'b0;
        r = cyc;
        // R1: first tick position and spacing
        @(negedge clk);
        while (!slot_tick) @(negedge clk);
        first = cyc;
        chk("R1 first tick", first - r, 15);
        @(negedge clk);
        chk("R1 tick width", {31'h0, slot_tick}, 32'h0);
        while (!slot_tick) @(negedge clk);
        chk("R1 tick period", cyc - first, 16);

        // R2, R5: streaming frequency write, native latency
        port_write(4'b0010, 32'hDEAD_BEEF, "R2 R5 stream freq");
        // R3, R5: amplitude/phase, bits [15:12] set but ignored
        port_write(4'b0100, 32'h1234_F789, "R3 R5 stream amp/phase");
        drain();
        // R4: undecoded codes
        port_write(4'b1111, 32'hFFFF_FFFF, "R4 code F");
        expect_hold("R4 code F hold");
        port_write(4'b0001, 32'h0BAD_0BAD, "R4 code 1");
        expect_hold("R4 code 1 hold");
        drain();

        // R8: matched latency, streaming
        set_mode(1'b1, 1'b1);
        port_write(4'b0010, 32'h0000_1111, "R8 matched freq");
        port_write(4'b0100, 32'hCAFE_0ABC, "R8 matched amp/phase");
        drain();

        // R6: staged mode, two slots, one update
        set_mode(1'b0, 1'b0);
        port_write(4'b0010, 32'h5555_AAAA, "R6 staged freq");
        port_write(4'b0100, 32'h7777_0123, "R6 staged amp/phase");
        expect_hold("R6 frozen before update");
        drain();
        pulse_update("R6 release");
        drain();
        // R7: second update with nothing pending
        pulse_update("R7 empty update");
        expect_hold("R7 no change");
        drain();
        // R4 in staged mode: undecoded then update
        port_write(4'b1000, 32'h1357_9BDF, "R4 staged code 8");
        pulse_update("R4 staged update");
        expect_hold("R4 staged hold");
        drain();

        // R8 with staged release
        set_mode(1'b0, 1'b1);
        port_write(4'b0010, 32'h2468_ACE0, "R8 staged freq");
        port_write(4'b0100, 32'h4321_0FED, "R8 staged amp/phase");
        drain();
        push_f(cyc + 2, mf, "R8 staged early");
        push_p(cyc + 2, mp, "R8 staged early");
        pulse_update("R8 staged matched");
        drain();

        // R11: streaming discards staged writes
        set_mode(1'b0, 1'b0);
        port_write(4'b0010, 32'h9999_0000, "R11 staged freq");
        set_mode(1'b1, 1'b0);
        set_mode(1'b0, 1'b0);
        pulse_update("R11 stale update");
        expect_hold("R11 no change");
        drain();

        // R9: amplitude gate
        @(negedge clk);
        amp_ctl_en = 1'b0;
        #1;
        chk("R9 gate off", {20'h0, core_amp}, 32'h0000_0FFF);
        @(negedge clk);
        amp_ctl_en = 1'b1;
        #1;
        chk("R9 gate on", {20'h0, core_amp}, {20'h0, ma});

        repeat (4) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule